// File: doc/BRIEF.md
# Watchdog Timer with Paired Clear

This block is a watchdog counter that advances on single-cycle enable pulses from a slow watchdog clock. A 3-bit period field sets the expiry period to one of eight powers of two, from 2^8 to 2^15 enable pulses. When the count expires and the system is running, the block sends a full device reset request. When the count expires and the system is asleep or idle, it sends a wake request together with a partial reset request. The partial reset covers only the program counter and stack pointer. Every expiry also sets a sticky time-out flag.

Software keeps the watchdog from expiring with clear strobes. A static mode input picks one of two schemes. In single-clear mode, one command clears the counter. In paired-clear mode, a strobe clears the counter only when it is of the opposite type to the last accepted strobe. Repeating the same strobe does nothing. An external reset held low, a halt strobe and a write to the period field also clear the counter.

Top module: `wdog_paired`

## Requirements
- R1: After power-on reset, the period register reads 8'h07, which selects the longest period. Bits 7..3 always read 0. A write keeps only bits 2..0 of the written byte.
- R2: With period field value s, the expiry happens on the 2^(8+s)-th enable pulse after the counter was last cleared. The request outputs rise in the clock cycle after the edge at which that pulse is sampled.
- R3: An expiry while `sleeping` is low gives a one-cycle pulse on `fullRstReq`. In that case `wakeReq` and `partRstReq` stay low.
- R4: An expiry while `sleeping` is high gives a one-cycle pulse on both `wakeReq` and `partRstReq`. In that case `fullRstReq` stays low.
- R5: `toFlag` is set on every expiry. It stays set until `toFlagClr` is pulsed or power-on reset is applied. If an expiry and `toFlagClr` occur in the same cycle, the set wins.
- R6: While `extRstN` is low, the counter is held at zero and enable pulses are not counted. The paired-clear history also returns to its neutral state.
- R7: A `haltStrobe` pulse clears the counter.
- R8: In single-clear mode (`pairedMode` = 0), a `clrOne` pulse clears the counter and `clrTwo` has no effect.
- R9: In paired-clear mode (`pairedMode` = 1), a clear strobe clears the counter when its type differs from the last accepted strobe. After any reset, the first strobe of either type is accepted.
- R10: In paired-clear mode, a strobe of the same type as the last accepted one has no effect. A cycle in which `clrOne` and `clrTwo` are both high also has no effect.
- R11: A write to the period register clears the counter.
- R12: The counter advances only in cycles where `tickEn` is high. Idle cycles do not change the time left to expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| extRstN | input | 1 | External reset level, active low; clears the counter and the pairing history |
| tickEn | input | 1 | One-cycle watchdog clock enable pulse |
| selWrEn | input | 1 | Period register write strobe |
| selWrData | input | 8 | Period register write data |
| selRdData | output | 8 | Period register read data |
| pairedMode | input | 1 | Static clear scheme: 0 selects single clear, 1 selects paired clear |
| clrOne | input | 1 | Clear command of the first type |
| clrTwo | input | 1 | Clear command of the second type |
| haltStrobe | input | 1 | Halt event strobe; clears the counter |
| sleeping | input | 1 | High while the system is in sleep or idle |
| toFlagClr | input | 1 | Clears the time-out flag |
| fullRstReq | output | 1 | Full device reset request pulse |
| partRstReq | output | 1 | Program counter and stack pointer reset request pulse |
| wakeReq | output | 1 | Wake-up request pulse |
| toFlag | output | 1 | Sticky time-out flag |

## Verification
The assertions check on every cycle that each request is a single-cycle pulse and that the full-reset and wake requests are mutually exclusive. They also check that every request arrives with the flag set and follows a sampled enable pulse, that no request follows a cycle with the external reset held low, and that the flag holds without a clear. Checking the exact expiry count for a period value needs long scenarios, and so do the effects of each clear source and the accept or ignore outcome of each strobe order in the two clear schemes. The bench's directed scenarios cover these by counting enable pulses to one short of expiry and then to expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // History of the last accepted clear command in paired mode
  typedef enum logic [1:0] {
    PAIR_NONE = 2'd0,
    PAIR_ONE  = 2'd1,
    PAIR_TWO  = 2'd2
  } pairState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntClr;   // zero the counter this cycle
    logic advance;  // count one enable pulse this cycle
  } wdStrobe_t;

endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extRstN,
  input  logic             tickEn,
  input  logic             selWrEn,
  input  logic [REG_W-1:0] selWrData,
  input  logic             pairedMode,
  input  logic             clrOne,
  input  logic             clrTwo,
  input  logic             haltStrobe,
  output logic [SEL_W-1:0] selVal,
  output logic [REG_W-1:0] selRdData,
  output wdStrobe_t        strb
);

  localparam int PAD_W = REG_W - SEL_W;

  logic [SEL_W-1:0] selQ;
  pairState_e       pairQ;
  pairState_e       pairNext;
  logic             swAccept;
  logic             unusedHiBits;

  assign unusedHiBits = ^selWrData[REG_W-1:SEL_W];

  // Period select register, resets to the longest period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= {SEL_W{1'b1}};
    end else if (selWrEn) begin
      selQ <= selWrData[SEL_W-1:0];
    end
  end

  assign selVal    = selQ;
  assign selRdData = {{PAD_W{1'b0}}, selQ};

  // Software clear decision
  always_comb begin
    swAccept = 1'b0;
    pairNext = pairQ;
    if (pairedMode) begin
      if (clrOne && !clrTwo && (pairQ != PAIR_ONE)) begin
        swAccept = 1'b1;
        pairNext = PAIR_ONE;
      end else if (clrTwo && !clrOne && (pairQ != PAIR_TWO)) begin
        swAccept = 1'b1;
        pairNext = PAIR_TWO;
      end
    end else begin
      swAccept = clrOne;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pairQ <= PAIR_NONE;
    end else if (!extRstN) begin
      pairQ <= PAIR_NONE;
    end else begin
      pairQ <= pairNext;
    end
  end

  always_comb begin
    strb.cntClr  = !extRstN || haltStrobe || swAccept || selWrEn;
    strb.advance = tickEn && !strb.cntClr;
  end

endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int MIN_EXP = 8,
  parameter int SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobe_t        strb,
  input  logic [SEL_W-1:0] selVal,
  input  logic             sleeping,
  input  logic             toFlagClr,
  output logic             fullRstReq,
  output logic             partRstReq,
  output logic             wakeReq,
  output logic             toFlag
);

  localparam int NSEL  = 1 << SEL_W;
  localparam int CNT_W = MIN_EXP + NSEL - 1;

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] limitTbl [NSEL];
  logic [CNT_W-1:0] limitSel;
  logic             expire;

  // Terminal count for each period value: 2^(MIN_EXP+g) - 1
  for (genvar g = 0; g < NSEL; g++) begin : g_limit
    assign limitTbl[g] = {CNT_W{1'b1}} >> (NSEL - 1 - g);
  end

  assign limitSel = limitTbl[selVal];
  assign expire   = strb.advance && (cntQ == limitSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strb.cntClr || expire) begin
      cntQ <= '0;
    end else if (strb.advance) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fullRstReq <= 1'b0;
      partRstReq <= 1'b0;
      wakeReq    <= 1'b0;
    end else begin
      fullRstReq <= expire && !sleeping;
      partRstReq <= expire && sleeping;
      wakeReq    <= expire && sleeping;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toFlag <= 1'b0;
    end else if (expire) begin
      toFlag <= 1'b1;
    end else if (toFlagClr) begin
      toFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/wdog_paired.sv
module wdog_paired
  import wdog_pkg::*;
#(
  parameter int MIN_EXP = 8,
  parameter int SEL_W   = 3,
  parameter int REG_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extRstN,
  input  logic             tickEn,
  input  logic             selWrEn,
  input  logic [REG_W-1:0] selWrData,
  output logic [REG_W-1:0] selRdData,
  input  logic             pairedMode,
  input  logic             clrOne,
  input  logic             clrTwo,
  input  logic             haltStrobe,
  input  logic             sleeping,
  input  logic             toFlagClr,
  output logic             fullRstReq,
  output logic             partRstReq,
  output logic             wakeReq,
  output logic             toFlag
);

  wdStrobe_t        strb;
  logic [SEL_W-1:0] selVal;

  wdog_ctrl #(
    .SEL_W (SEL_W),
    .REG_W (REG_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .extRstN    (extRstN),
    .tickEn     (tickEn),
    .selWrEn    (selWrEn),
    .selWrData  (selWrData),
    .pairedMode (pairedMode),
    .clrOne     (clrOne),
    .clrTwo     (clrTwo),
    .haltStrobe (haltStrobe),
    .selVal     (selVal),
    .selRdData  (selRdData),
    .strb       (strb)
  );

  wdog_dp #(
    .MIN_EXP (MIN_EXP),
    .SEL_W   (SEL_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .selVal     (selVal),
    .sleeping   (sleeping),
    .toFlagClr  (toFlagClr),
    .fullRstReq (fullRstReq),
    .partRstReq (partRstReq),
    .wakeReq    (wakeReq),
    .toFlag     (toFlag)
  );

endmodule

// File: rtl/wdog_paired_chk.sv
module wdog_paired_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             extRstN,
  input logic             tickEn,
  input logic             selWrEn,
  input logic [REG_W-1:0] selWrData,
  input logic [REG_W-1:0] selRdData,
  input logic             toFlagClr,
  input logic             fullRstReq,
  input logic             partRstReq,
  input logic             wakeReq,
  input logic             toFlag
);

  // R1: a write is visible in the low bits on the next cycle
  p_sel_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    selWrEn |=> (selRdData[2:0] == $past(selWrData[2:0])));

  // R3: full reset request lasts one cycle
  p_full_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    fullRstReq |=> !fullRstReq);

  // R3, R4: full reset and wake never together
  p_req_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(fullRstReq && (wakeReq || partRstReq)));

  // R4: wake comes with a partial reset and lasts one cycle
  p_wake_part_r4: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> partRstReq);
  p_wake_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |=> !wakeReq);

  // R5: every request comes with the flag set
  p_flag_on_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fullRstReq || wakeReq) |-> toFlag);

  // R5: flag holds without a clear
  p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (toFlag && !toFlagClr) |=> toFlag);

  // R6: no request right after external reset held low
  p_ext_block_r6: assert property (@(posedge clk) disable iff (!rstN)
    !extRstN |=> !(fullRstReq || wakeReq));

  // R12: a request only follows a sampled enable pulse
  p_tick_only_r12: assert property (@(posedge clk) disable iff (!rstN)
    (fullRstReq || wakeReq) |-> $past(tickEn));

endmodule

bind wdog_paired wdog_paired_chk #(.REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .extRstN    (extRstN),
  .tickEn     (tickEn),
  .selWrEn    (selWrEn),
  .selWrData  (selWrData),
  .selRdData  (selRdData),
  .toFlagClr  (toFlagClr),
  .fullRstReq (fullRstReq),
  .partRstReq (partRstReq),
  .wakeReq    (wakeReq),
  .toFlag     (toFlag)
);

// File: tb/wdog_paired_bench.sv
module wdog_paired_bench;

  logic       clk = 1'b0;
  logic       rstN, extRstN, tickEn, selWrEn;
  logic [7:0] selWrData, selRdData;
  logic       pairedMode, clrOne, clrTwo, haltStrobe, sleeping, toFlagClr;
  logic       fullRstReq, partRstReq, wakeReq, toFlag;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wdog_paired u_wdog_paired (
    .clk        (clk),
    .rstN       (rstN),
    .extRstN    (extRstN),
    .tickEn     (tickEn),
    .selWrEn    (selWrEn),
    .selWrData  (selWrData),
    .selRdData  (selRdData),
    .pairedMode (pairedMode),
    .clrOne     (clrOne),
    .clrTwo     (clrTwo),
    .haltStrobe (haltStrobe),
    .sleeping   (sleeping),
    .toFlagClr  (toFlagClr),
    .fullRstReq (fullRstReq),
    .partRstReq (partRstReq),
    .wakeReq    (wakeReq),
    .toFlag     (toFlag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runTicks(input int n);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic writeSel(input logic [7:0] v);
    selWrEn = 1'b1; selWrData = v;
    @(negedge clk);
    selWrEn = 1'b0;
  endtask

  task automatic clearFlag();
    toFlagClr = 1'b1;
    @(negedge clk);
    toFlagClr = 1'b0;
  endtask

  // 0 one, 1 two, 2 both, 3 halt
  task automatic strobe(input int kind);
    clrOne     = (kind == 0) || (kind == 2);
    clrTwo     = (kind == 1) || (kind == 2);
    haltStrobe = (kind == 3);
    @(negedge clk);
    clrOne = 1'b0; clrTwo = 1'b0; haltStrobe = 1'b0;
  endtask

  // n ticks to expiry: no flag after n-1, request after n
  task automatic expectExpiry(input string req, input int n);
    runTicks(n - 1);
    chk({req, " no early expiry"}, toFlag, 1'b0);
    runTicks(1);
    chk({req, " expiry flag"}, toFlag, 1'b1);
    chk({req, " full request"}, fullRstReq, !sleeping);
    chk({req, " wake request"}, wakeReq, sleeping);
    chk({req, " partial request"}, partRstReq, sleeping);
    @(negedge clk);
    chk({req, " request is one pulse"}, {fullRstReq, wakeReq, partRstReq}, 3'b000);
    clearFlag();
  endtask

  task automatic tResetState();
    chk("R1 reset period read", selRdData, 8'h07);
    chk("R5 reset flag", toFlag, 1'b0);
    chk("R3 reset requests", {fullRstReq, wakeReq, partRstReq}, 3'b000);
  endtask

  task automatic tLongest();
    expectExpiry("R2 R3 longest period", 32768);
  endtask

  task automatic tSelReg();
    writeSel(8'hFF);
    chk("R1 upper bits read zero", selRdData, 8'h07);
    writeSel(8'hA2);
    chk("R1 low bits kept", selRdData, 8'h02);
  endtask

  task automatic tFlag();
    writeSel(8'h00);
    runTicks(256);
    @(negedge clk);
    chk("R5 flag sticky", toFlag, 1'b1);
    clearFlag();
    chk("R5 flag cleared", toFlag, 1'b0);
    // set wins over clear in the same cycle
    runTicks(255);
    toFlagClr = 1'b1; tickEn = 1'b1;
    @(negedge clk);
    toFlagClr = 1'b0; tickEn = 1'b0;
    chk("R5 set wins over clear", toFlag, 1'b1);
    clearFlag();
  endtask

  task automatic tShortIdle();
    writeSel(8'h00);
    runTicks(100);
    repeat (50) @(negedge clk);
    expectExpiry("R2 R12 shortest period with idle gaps", 156);
    writeSel(8'h03);
    expectExpiry("R2 period 2^11", 2048);
  endtask

  task automatic tSleep();
    sleeping = 1'b1;
    writeSel(8'h00);
    expectExpiry("R4 expiry while asleep", 256);
    sleeping = 1'b0;
  endtask

  task automatic tSelClr();
    writeSel(8'h00);
    runTicks(200);
    writeSel(8'h00);
    expectExpiry("R11 period write clears", 256);
  endtask

  task automatic tHalt();
    writeSel(8'h00);
    runTicks(200);
    strobe(3);
    expectExpiry("R7 halt clears", 256);
  endtask

  task automatic tExt();
    writeSel(8'h00);
    runTicks(200);
    extRstN = 1'b0;
    runTicks(20);
    extRstN = 1'b1;
    expectExpiry("R6 external reset clears and holds", 256);
  endtask

  task automatic tSingle();
    pairedMode = 1'b0;
    writeSel(8'h00);
    runTicks(200);
    strobe(1);
    expectExpiry("R8 second command ignored in single mode", 56);
    runTicks(100);
    strobe(0);
    expectExpiry("R8 single clear", 256);
  endtask

  task automatic tPaired();
    pairedMode = 1'b1;
    writeSel(8'h00);
    runTicks(100);
    strobe(0);
    runTicks(200);
    strobe(0);
    expectExpiry("R9 R10 first accepted then repeat of first ignored", 56);
    runTicks(100);
    strobe(1);
    expectExpiry("R9 alternate two after one accepted", 256);
    runTicks(100);
    strobe(1);
    expectExpiry("R10 repeat of second ignored", 156);
    runTicks(100);
    strobe(0);
    expectExpiry("R9 alternate one after two accepted", 256);
    runTicks(100);
    strobe(2);
    expectExpiry("R10 both at once ignored", 156);
  endtask

  task automatic tPairedExt();
    // last accepted is one; external reset returns history to neutral
    extRstN = 1'b0;
    @(negedge clk);
    extRstN = 1'b1;
    runTicks(100);
    strobe(0);
    expectExpiry("R6 pairing history neutral after external reset", 256);
  endtask

  initial begin
    rstN = 1'b0; extRstN = 1'b1; tickEn = 1'b0; selWrEn = 1'b0; selWrData = '0;
    pairedMode = 1'b0; clrOne = 1'b0; clrTwo = 1'b0; haltStrobe = 1'b0;
    sleeping = 1'b0; toFlagClr = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tResetState();
    tLongest();
    tSelReg();
    tFlag();
    tShortIdle();
    tSleep();
    tSelClr();
    tHalt();
    tExt();
    tSingle();
    tPaired();
    tPairedExt();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule